// File: doc/BRIEF.md
# Packed Saturating Lane Adder

This block adds two 64-bit registers as a packed vector of independent lanes. A run-time width code splits the register into one 64-bit lane, two 32-bit lanes, four 16-bit lanes or eight 8-bit lanes. Every lane computes `a + b + cin` on its own. The same carry-in enters every lane, and no carry crosses a lane boundary. Each lane reports three things: the carry out of its own top bit, an optional saturated result, and a 4-bit condition field. The condition field carries the sign class of the final lane value and an overflow flag that describes only this operation.

Each lane's condition field is tagged with a field number. The number is the element base index supplied with the operation plus the lane number, modulo 128. This tag lets a downstream register file write each element's field into its own slot.

Operations enter through a valid/ready input stream and leave through a valid/ready output stream. A single output register sits between the two streams. A new operation is accepted in any cycle where the output register is empty, or is being emptied in that same cycle. A result that is waiting while the consumer holds `out_ready` low stays exactly as it is. The input and output ports carry one operation per beat. The result is visible one cycle after acceptance.

Top module: `packed_sat_adder`

## Requirements
- R1: The width code `in_ew` selects the lane width: 0 = 64 bits, 1 = 32, 2 = 16, 3 = 8. Lane e occupies bits [e*W +: W]. The carry-in is added into every lane, and no lane ever receives a carry from another lane.
- R2: With `in_sat` = 0 (wrap), each lane result is (a + b + cin) mod 2^W.
- R3: `out_cout[e]` is bit W of the unsigned sum of lane e, which is the bit just above the lane width. The carry-out bits of lanes that are not in use are 0.
- R4: With `in_sat` = 1 (signed), a lane whose exact signed sum exceeds the W-bit signed range is clamped. A sum that is too large becomes 2^(W-1)-1, and a sum that is too small becomes -2^(W-1).
- R5: With `in_sat` = 2 (unsigned), the operands are read as unsigned. A lane whose exact sum exceeds 2^W-1 becomes all ones.
- R6: With `in_sat` = 3 (signed in, unsigned out), the operands are read as signed. A lane whose exact sum is negative becomes 0. Otherwise the lane holds the sum itself.
- R7: The condition field of lane e is `out_cf[4e+3:4e]` = {LT, GT, EQ, OV}. LT, GT and EQ compare the final lane value, read as signed, against zero, and exactly one of them is set for a lane in use. Lanes not in use report 0000.
- R8: OV is set when the current operation overflows. In modes 0 and 1 this means signed overflow. In mode 2 it means an unsigned carry out of the lane. In mode 3 it means a negative exact sum. OV depends on nothing from earlier operations.
- R9: `out_fidx[7e+6:7e]` equals (`in_base` + e) mod 128 for each lane in use, and 0 for lanes not in use.
- R10: `in_ready` is high when the output register is empty or `out_ready` is high. An accepted operation appears on the output in the next cycle. While `out_valid` is high and `out_ready` is low, every output stays unchanged.
- R11: During reset and after it, `out_valid` is 0 and `in_ready` is 1 until the first operation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operation valid |
| in_ready | output | 1 | Input operation can be accepted |
| in_a | input | 64 | First packed operand |
| in_b | input | 64 | Second packed operand |
| in_ew | input | 2 | Lane width code |
| in_cin | input | 1 | Carry-in added to every lane |
| in_sat | input | 2 | Saturation mode |
| in_base | input | 7 | Field number of lane 0 |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_sum | output | 64 | Packed lane results |
| out_cout | output | 8 | Per-lane carry-out |
| out_cf | output | 32 | Per-lane condition fields |
| out_fidx | output | 56 | Per-lane field numbers |

## Verification
The bench builds the block with its defaults: a 64-bit register and 7-bit field numbers. With these values, all four lane widths, including the 8-lane split, are reached with a single build. Base indices close to 127 make the field-number wrap visible. Directed lane patterns at each width drive every saturation mode across its positive and negative limits. Random operations, combined with a randomly stalled consumer, exercise the hold rule and back-to-back acceptance.

// File: rtl/psa_pkg.sv
package psa_pkg;

  typedef enum logic [1:0] {
    SAT_WRAP     = 2'd0,
    SAT_SIGNED   = 2'd1,
    SAT_UNSIGNED = 2'd2,
    SAT_S2U      = 2'd3
  } sat_mode_e;

  localparam int CF_W  = 4;
  localparam int CF_LT = 3;
  localparam int CF_GT = 2;
  localparam int CF_EQ = 1;
  localparam int CF_OV = 0;

  // Number of selectable widths: full, half, quarter, eighth.
  localparam int NUM_WIDTHS = 4;

  function automatic logic [CF_W-1:0] pack_cf(input logic lt, input logic gt,
                                              input logic eq, input logic ov);
    logic [CF_W-1:0] f;
    f        = '0;
    f[CF_LT] = lt;
    f[CF_GT] = gt;
    f[CF_EQ] = eq;
    f[CF_OV] = ov;
    return f;
  endfunction

endpackage

// File: rtl/psa_elem.sv
module psa_elem
  import psa_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic            cin,
  input  sat_mode_e       sat,
  output logic [W-1:0]    res,
  output logic            cout,
  output logic [CF_W-1:0] cf
);

  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W:0] usum;
  logic [W:0] ssum;
  logic       s_ovf;
  logic       u_ovf;
  logic       s_neg;
  logic       ov;
  logic       lt;
  logic       eq;

  // W+1 bits hold the exact sum for both the unsigned and signed readings.
  assign usum  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign ssum  = {a[W-1], a} + {b[W-1], b} + {{W{1'b0}}, cin};
  assign s_ovf = ssum[W] ^ ssum[W-1];
  assign u_ovf = usum[W];
  assign s_neg = ssum[W];
  assign cout  = usum[W];

  always_comb begin
    res = usum[W-1:0];
    ov  = s_ovf;
    unique case (sat)
      SAT_WRAP: begin
        res = usum[W-1:0];
        ov  = s_ovf;
      end
      SAT_SIGNED: begin
        ov = s_ovf;
        if (s_ovf) res = s_neg ? MIN_NEG : MAX_POS;
        else       res = ssum[W-1:0];
      end
      SAT_UNSIGNED: begin
        ov  = u_ovf;
        res = u_ovf ? {W{1'b1}} : usum[W-1:0];
      end
      SAT_S2U: begin
        ov  = s_neg;
        res = s_neg ? '0 : ssum[W-1:0];
      end
      default: begin
        res = usum[W-1:0];
        ov  = s_ovf;
      end
    endcase
  end

  assign lt = res[W-1];
  assign eq = (res == '0);
  assign cf = pack_cf(lt, !lt && !eq, eq, ov);

endmodule

// File: rtl/psa_bank.sv
module psa_bank
  import psa_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int W     = 64,
  parameter int LANES = 8
) (
  input  logic [XLEN-1:0]       a,
  input  logic [XLEN-1:0]       b,
  input  logic                  cin,
  input  sat_mode_e             sat,
  output logic [XLEN-1:0]       res,
  output logic [LANES-1:0]      cout,
  output logic [LANES*CF_W-1:0] cf
);

  localparam int NE = XLEN / W;

  for (genvar e = 0; e < NE; e++) begin : g_lane
    psa_elem #(.W(W)) u_elem (
      .a    (a[e*W +: W]),
      .b    (b[e*W +: W]),
      .cin  (cin),
      .sat  (sat),
      .res  (res[e*W +: W]),
      .cout (cout[e]),
      .cf   (cf[e*CF_W +: CF_W])
    );
  end

  if (NE < LANES) begin : g_idle
    assign cout[LANES-1:NE]           = '0;
    assign cf[LANES*CF_W-1:NE*CF_W]   = '0;
  end

endmodule

// File: rtl/packed_sat_adder.sv
module packed_sat_adder
  import psa_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int FIDX_W = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [XLEN-1:0]          in_a,
  input  logic [XLEN-1:0]          in_b,
  input  logic [1:0]               in_ew,
  input  logic                     in_cin,
  input  logic [1:0]               in_sat,
  input  logic [FIDX_W-1:0]        in_base,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [XLEN-1:0]          out_sum,
  output logic [(1<<(psa_pkg::NUM_WIDTHS-1))-1:0]        out_cout,
  output logic [(1<<(psa_pkg::NUM_WIDTHS-1))*4-1:0]      out_cf,
  output logic [(1<<(psa_pkg::NUM_WIDTHS-1))*FIDX_W-1:0] out_fidx
);

  localparam int LANES = 1 << (NUM_WIDTHS - 1);

  sat_mode_e              sat_mode;
  logic [XLEN-1:0]        bank_res  [NUM_WIDTHS];
  logic [LANES-1:0]       bank_cout [NUM_WIDTHS];
  logic [LANES*CF_W-1:0]  bank_cf   [NUM_WIDTHS];
  logic [LANES*FIDX_W-1:0] fidx_c;
  logic                   accept;

  assign sat_mode = sat_mode_e'(in_sat);

  // One bank per width code; code g gives XLEN >> g bit lanes.
  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
    psa_bank #(.XLEN(XLEN), .W(XLEN >> g), .LANES(LANES)) u_bank (
      .a    (in_a),
      .b    (in_b),
      .cin  (in_cin),
      .sat  (sat_mode),
      .res  (bank_res[g]),
      .cout (bank_cout[g]),
      .cf   (bank_cf[g])
    );
  end

  for (genvar e = 0; e < LANES; e++) begin : g_fidx
    logic active;
    assign active = (e < (1 << in_ew));
    assign fidx_c[e*FIDX_W +: FIDX_W] = active ? FIDX_W'(in_base + FIDX_W'(e)) : '0;
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
      out_cout  <= '0;
      out_cf    <= '0;
      out_fidx  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (accept) begin
        out_sum  <= bank_res[in_ew];
        out_cout <= bank_cout[in_ew];
        out_cf   <= bank_cf[in_ew];
        out_fidx <= fidx_c;
      end
    end
  end

endmodule

// File: rtl/psa_chk.sv
module psa_chk #(
  parameter int XLEN   = 64,
  parameter int FIDX_W = 7,
  parameter int LANES  = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [XLEN-1:0]           out_sum,
  input logic [LANES-1:0]          out_cout,
  input logic [LANES*4-1:0]        out_cf,
  input logic [LANES*FIDX_W-1:0]   out_fidx
);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sum) && $stable(out_cout)
                                && $stable(out_cf) && $stable(out_fidx));

  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r7_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_cf[3:1]) == 1);

  a_r3_idle_cout: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_cf[LANES*4-1 -: 3] == 3'b000) |-> !out_cout[LANES-1]);

  a_r9_next_field: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_cf[6:4] != 3'b000)
      |-> out_fidx[2*FIDX_W-1:FIDX_W] == FIDX_W'(out_fidx[FIDX_W-1:0] + 1'b1));

  a_r11_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

endmodule

bind packed_sat_adder psa_chk #(.XLEN(XLEN), .FIDX_W(FIDX_W), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sum   (out_sum),
  .out_cout  (out_cout),
  .out_cf    (out_cf),
  .out_fidx  (out_fidx)
);

// File: tb/test_packed_sat_adder.sv
module test_packed_sat_adder;

  typedef struct packed {
    logic [63:0] sum;
    logic [7:0]  cout;
    logic [31:0] cf;
    logic [55:0] fidx;
    logic [1:0]  sat;
    logic [1:0]  ew;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_a = '0, in_b = '0;
  logic [1:0]  in_ew = '0, in_sat = '0;
  logic        in_cin = 1'b0;
  logic [6:0]  in_base = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_sum;
  logic [7:0]  out_cout;
  logic [31:0] out_cf;
  logic [55:0] out_fidx;

  int   checks = 0;
  int   errors = 0;
  bit   stall_mode = 1'b0;
  bit   wdog = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;

  packed_sat_adder i_packed_sat_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_ew(in_ew), .in_cin(in_cin), .in_sat(in_sat),
    .in_base(in_base), .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum), .out_cout(out_cout), .out_cf(out_cf), .out_fidx(out_fidx)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural model of one operation, per lane with wide integers.
  function automatic exp_t model(input logic [63:0] a, input logic [63:0] b,
                                 input logic [1:0] ew, input logic cin,
                                 input logic [1:0] sat, input logic [6:0] base);
    exp_t x;
    int   w;
    x = '0;
    x.sat = sat;
    x.ew  = ew;
    w = 64 >> ew;
    for (int e = 0; e < 8; e++) begin
      if (e < (1 << ew)) begin
        logic signed [67:0] maxu, half, ua, ub, sa, sb, eu, es, r, rs;
        logic [67:0] rm;
        logic ov;
        maxu = (68'sd1 <<< w) - 68'sd1;
        half = 68'sd1 <<< (w - 1);
        ua = ($signed({4'b0, a}) >>> (e * w)) & maxu;
        ub = ($signed({4'b0, b}) >>> (e * w)) & maxu;
        sa = (ua >= half) ? ua - (maxu + 68'sd1) : ua;
        sb = (ub >= half) ? ub - (maxu + 68'sd1) : ub;
        eu = ua + ub + (cin ? 68'sd1 : 68'sd0);
        es = sa + sb + (cin ? 68'sd1 : 68'sd0);
        case (sat)
          2'd0: begin r = eu & maxu; ov = (es >= half) || (es < -half); end
          2'd1: begin
            ov = (es >= half) || (es < -half);
            r  = (es >= half) ? half - 68'sd1 : (es < -half) ? -half : es;
          end
          2'd2: begin ov = eu > maxu; r = ov ? maxu : eu; end
          default: begin ov = es < 0; r = ov ? 68'sd0 : es; end
        endcase
        rm = r & maxu;
        rs = (rm >= half) ? $signed(rm) - (maxu + 68'sd1) : $signed(rm);
        x.sum  = x.sum | 64'(rm << (e * w));
        x.cout[e] = eu > maxu;
        x.cf[e*4 +: 4] = {rs < 0, rs > 0, rs == 0, ov};
        x.fidx[e*7 +: 7] = 7'(base + 7'(e));
      end
    end
    return x;
  endfunction

  function automatic logic [63:0] rep(input logic [1:0] ew, input logic [63:0] v);
    logic [63:0] r;
    int w;
    w = 64 >> ew;
    r = '0;
    for (int e = 0; e < (1 << ew); e++)
      r = r | ((v & ((w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1))) << (e * w));
    return r;
  endfunction

  task automatic send(input logic [63:0] a, input logic [63:0] b, input logic [1:0] ew,
                      input logic cin, input logic [1:0] sat, input logic [6:0] base);
    @(negedge clk); #1;
    in_a = a; in_b = b; in_ew = ew; in_cin = cin; in_sat = sat; in_base = base;
    in_valid = 1'b1;
    out_ready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
    forever begin
      #1;
      if (in_ready) begin
        q.push_back(model(a, b, ew, cin, sat, base));
        break;
      end
      @(negedge clk); #1;
      out_ready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
    end
    @(negedge clk); #1;
    in_valid = 1'b0;
    out_ready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
  endtask

  // Output monitor: sampled after the drivers settle, before the next edge.
  bit          held = 1'b0;
  logic [63:0] h_sum;
  logic [31:0] h_cf;
  logic [55:0] h_fidx;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (held && out_valid)
        check(out_sum == h_sum && out_cf == h_cf && out_fidx == h_fidx,
              "R10 hold while stalled", out_sum, h_sum);
      held = 1'b0;
      if (out_valid && !out_ready) begin
        held = 1'b1; h_sum = out_sum; h_cf = out_cf; h_fidx = out_fidx;
      end
      check(in_ready == (!out_valid || out_ready), "R10 in_ready", 64'(in_ready),
            64'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R10 unexpected beat", out_sum, 64'd0);
        end else begin
          exp_t x;
          string tag;
          x = q.pop_front();
          case (x.sat)
            2'd0: tag = (x.ew != 0) ? "R1 lane sum" : "R2 wrap sum";
            2'd1: tag = "R4 signed sat";
            2'd2: tag = "R5 unsigned sat";
            default: tag = "R6 negative to zero";
          endcase
          check(out_sum == x.sum, tag, out_sum, x.sum);
          check(out_cout == x.cout, "R3 carry-out", 64'(out_cout), 64'(x.cout));
          check((out_cf & 32'hEEEE_EEEE) == (x.cf & 32'hEEEE_EEEE), "R7 cond field",
                64'(out_cf), 64'(x.cf));
          check((out_cf & 32'h1111_1111) == (x.cf & 32'h1111_1111), "R8 overflow bit",
                64'(out_cf), 64'(x.cf));
          check(out_fidx == x.fidx, "R9 field index", 64'(out_fidx), 64'(x.fidx));
        end
      end
    end
  end

  task automatic run_all();
    // R11: reset state
    repeat (3) @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R11 valid in reset", 64'(out_valid), 64'd0);
    @(negedge clk); #1; rst_n = 1'b1;
    @(negedge clk); #2;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R11 idle after reset",
          64'({out_valid, in_ready}), 64'b01);
    // R1: no carry across lanes
    send(64'hFFFF_FFFF_FFFF_FFFF, rep(2'd3, 64'h01), 2'd3, 1'b0, 2'd0, 7'd0);
    send(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 2'd2, 1'b1, 2'd0, 7'd5);
    // Directed limits for every width and mode
    for (int ew = 0; ew < 4; ew++) begin
      for (int s = 0; s < 4; s++) begin
        int w;
        logic [63:0] mp, mn, one, ones;
        w = 64 >> ew;
        ones = 64'hFFFF_FFFF_FFFF_FFFF;
        one  = 64'd1;
        mp   = ones >> (65 - w);
        mn   = 64'd1 << (w - 1);
        send(rep(2'(ew), mp), rep(2'(ew), one), 2'(ew), 1'b0, 2'(s), 7'd126);
        send(rep(2'(ew), mn), rep(2'(ew), ones), 2'(ew), 1'b0, 2'(s), 7'd3);
        send(rep(2'(ew), ones), rep(2'(ew), one), 2'(ew), 1'b1, 2'(s), 7'd124);
        send(64'd0, 64'd0, 2'(ew), 1'b0, 2'(s), 7'd127);
        send(rep(2'(ew), 64'd5), rep(2'(ew), ones - 64'd4), 2'(ew), 1'b0, 2'(s), 7'd64);
        send(rep(2'(ew), mp), rep(2'(ew), mp), 2'(ew), 1'b1, 2'(s), 7'd10);
      end
    end
    // Random traffic with a stalling consumer
    stall_mode = 1'b1;
    for (int i = 0; i < 400; i++)
      send({$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 7'($urandom_range(0, 127)));
    stall_mode = 1'b0;
    @(negedge clk); #1; out_ready = 1'b1;
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin repeat (100000) @(posedge clk); wdog = 1'b1; end
    join_any
    disable fork;
    if (wdog) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule